// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the host write cycles aimed at a NOR flash array and recognises multi-cycle command sequences. Each sequence opens with two unlock writes to fixed low addresses, followed by a command byte. Some commands need further cycles: a program takes one more cycle, and an erase takes an 80h byte, a second unlock pair and a final byte. The block keeps track of how far a sequence has got. It holds the read mode that the array's read path must use (normal array data, identification words, query table or hidden area), and it keeps a flag for fast two-cycle programming. When a program or erase sequence completes, the block raises a one-clock request to the embedded algorithm engine. It also raises single-cycle suspend and resume requests.

Unlock addresses depend on the bus width. In word mode the block compares the low eleven word-address bits. In byte mode the byte-lane bit joins them below. Only the low data byte carries a command. While the engine reports busy, the block discards every write except a suspend. The block also returns the identification word selected by three address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `read_mode` is 0 (array), `fast_mode` is 0 and every request strobe is low.
- R2: Unlock cycles are AAh then 55h. In word mode they go to word addresses 555h then 2AAh, compared on `wr_addr[10:0]` only. In byte mode they go to byte addresses AAAh then 555h, where the byte address is {`wr_addr[10:0]`,`byte_lsb`}. Address bits above bit 10 and `wr_data[15:8]` do not affect decoding.
- R3: A single F0h write at any address, or F0h as the cycle after an unlock pair, sets `read_mode` to 0 from ID or query mode. F0h leaves hidden mode (3) unchanged.
- R4: An unlock pair followed by 90h at any address sets `read_mode` to 1 (ID). `id_word` follows `id_sel` = {A6,A1,A0}: 000 gives 0098h. 001 gives 0093h, or 0095h when BOTTOM_BOOT is set. 010 gives 0001h when `blk_protected` is high and 0000h otherwise. Every other value gives 0000h.
- R5: An unlock pair, then A0h, then a write of address and data raises `prog_stb` for one clock, one cycle after that last write. During that clock `op_data` holds the written data and `op_addr` holds the target. The target is {0,`wr_addr`} in word mode and {`wr_addr`,`byte_lsb`} in byte mode. In byte mode `op_data[15:8]` is 0.
- R6: An unlock pair, 80h, a second unlock pair and then one of two final writes starts an erase. A 30h final write at any address raises `erase_blk_stb`, and `op_addr` holds that address. A 10h final write at the first unlock address raises `erase_chip_stb`.
- R7: While `engine_busy` is high, a B0h write at any address raises `suspend_stb` for one clock. While the engine is not busy, a 30h write with no sequence in progress raises `resume_stb`.
- R8: An unlock pair followed by 20h sets `fast_mode`. In fast mode, A0h followed by an address and data write raises `prog_stb` as in R5. 90h followed by F0h or 00h clears `fast_mode`. Other writes in fast mode have no effect.
- R9: An unlock pair followed by 88h sets `read_mode` to 3 (hidden). An unlock pair, 90h and then 00h returns it to 0.
- R10: A single write of 98h at word address 55h (byte address AAh in byte mode) sets `read_mode` to 2 (query).
- R11: A write that breaks a sequence abandons the sequence, and `read_mode` keeps its value.
- R12: While `engine_busy` is high, every write other than B0h leaves the read mode, the fast flag, the sequence position and all strobes untouched.
- R13: At most one request strobe is high in any cycle, and no strobe stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-clock pulse per host write cycle |
| wr_addr | input | ADDR_W | Host word address |
| byte_lsb | input | 1 | Byte-lane bit below the word address, used in byte mode |
| wr_data | input | DATA_W | Host write data; the command is in bits 7:0 |
| byte_mode | input | 1 | 1 selects the 8-bit bus width |
| engine_busy | input | 1 | Embedded program/erase engine is running |
| id_sel | input | 3 | {A6,A1,A0} selecting the identification word |
| blk_protected | input | 1 | Protection state of the addressed block |
| read_mode | output | 2 | 0 array, 1 ID, 2 query, 3 hidden area |
| fast_mode | output | 1 | Fast two-cycle program mode active |
| prog_stb | output | 1 | Program request |
| erase_blk_stb | output | 1 | Block erase request |
| erase_chip_stb | output | 1 | Chip erase request |
| suspend_stb | output | 1 | Suspend request |
| resume_stb | output | 1 | Resume request |
| op_addr | output | ADDR_W+1 | Address latched for a program or erase |
| op_data | output | DATA_W | Data latched for a program |
| id_word | output | DATA_W | Identification word for `id_sel` |

## Verification
A suspend write and a partly entered erase sequence can meet. The bench opens an erase sequence, stops just before its final cycle, raises `engine_busy` and sends B0h followed by 30h. Only `suspend_stb` must appear, and the 30h must be dropped. After busy falls, a 30h write must complete the held sequence as a block erase (`erase_blk_stb`), not as a resume. A behavioural reference model checks every cycle so that the two functions remain distinct. The bench also checks that a 30h write with no sequence in progress produces the resume strobe.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_ID     = 2'd1,
        RM_CFI    = 2'd2,
        RM_HIDDEN = 2'd3
    } rmode_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA3,
        SQ_ERA4,
        SQ_ERA5,
        SQ_HEXIT,
        SQ_FPROG,
        SQ_FEXIT
    } seq_e;

    localparam logic [7:0] C_UNLOCK_A = 8'hAA;
    localparam logic [7:0] C_UNLOCK_B = 8'h55;
    localparam logic [7:0] C_RESET    = 8'hF0;
    localparam logic [7:0] C_ZERO     = 8'h00;
    localparam logic [7:0] C_IDENT    = 8'h90;
    localparam logic [7:0] C_PROGRAM  = 8'hA0;
    localparam logic [7:0] C_ERASE    = 8'h80;
    localparam logic [7:0] C_BLKERA   = 8'h30;
    localparam logic [7:0] C_CHIPERA  = 8'h10;
    localparam logic [7:0] C_SUSPEND  = 8'hB0;
    localparam logic [7:0] C_FASTSET  = 8'h20;
    localparam logic [7:0] C_HIDDEN   = 8'h88;
    localparam logic [7:0] C_QUERY    = 8'h98;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
    parameter int          CMP_W  = 11,
    parameter logic [10:0] W_UNL1 = 11'h555,
    parameter logic [10:0] W_UNL2 = 11'h2AA,
    parameter logic [10:0] W_QRY  = 11'h055
) (
    input  logic [CMP_W-1:0] addr_low,
    input  logic             lsb,
    input  logic             byte_mode,
    output logic             hit_unl1,
    output logic             hit_unl2,
    output logic             hit_query
);
    localparam int KEY_W = CMP_W + 1;

    logic [KEY_W-1:0] key;
    logic [KEY_W-1:0] ref_unl1;
    logic [KEY_W-1:0] ref_unl2;
    logic [KEY_W-1:0] ref_qry;

    // Byte-mode form of a word unlock address: word address shifted up,
    // lane bit chosen so that 555h->AAAh, 2AAh->555h, 055h->0AAh.
    function automatic logic [KEY_W-1:0] expand(input logic [10:0] w, input logic bm);
        logic [CMP_W-1:0] wn;
        wn = CMP_W'(w);
        if (bm) expand = {wn, ~wn[0]};
        else    expand = {1'b0, wn};
    endfunction

    always_comb begin
        key       = byte_mode ? {addr_low, lsb} : {1'b0, addr_low};
        ref_unl1  = expand(W_UNL1, byte_mode);
        ref_unl2  = expand(W_UNL2, byte_mode);
        ref_qry   = expand(W_QRY,  byte_mode);
        hit_unl1  = (key == ref_unl1);
        hit_unl2  = (key == ref_unl2);
        hit_query = (key == ref_qry);
    end

endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom #(
    parameter int          DATA_W      = 16,
    parameter bit          BOTTOM_BOOT = 1'b0,
    parameter logic [15:0] MFR_CODE    = 16'h0098,
    parameter logic [15:0] DEV_TOP     = 16'h0093,
    parameter logic [15:0] DEV_BOT     = 16'h0095
) (
    input  logic [2:0]        id_sel,
    input  logic              blk_protected,
    output logic [DATA_W-1:0] id_word
);
    logic [DATA_W-1:0] dev_code;

    generate
        if (BOTTOM_BOOT) begin : g_bottom
            assign dev_code = DATA_W'(DEV_BOT);
        end else begin : g_top
            assign dev_code = DATA_W'(DEV_TOP);
        end
    endgenerate

    always_comb begin
        case (id_sel)
            3'b000:  id_word = DATA_W'(MFR_CODE);
            3'b001:  id_word = dev_code;
            3'b010:  id_word = {{(DATA_W-1){1'b0}}, blk_protected};
            default: id_word = '0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 16,
    parameter int CMP_W       = 11,
    parameter bit BOTTOM_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_lsb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              engine_busy,
    input  logic [2:0]        id_sel,
    input  logic              blk_protected,
    output logic [1:0]        read_mode,
    output logic              fast_mode,
    output logic              prog_stb,
    output logic              erase_blk_stb,
    output logic              erase_chip_stb,
    output logic              suspend_stb,
    output logic              resume_stb,
    output logic [ADDR_W:0]   op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [DATA_W-1:0] id_word
);
    localparam int OPA_W = ADDR_W + 1;
    localparam int HALF  = DATA_W / 2;

    typedef struct packed {
        seq_e              seq;
        rmode_e            mode;
        logic              fast;
        logic              prog;
        logic              blk;
        logic              chip;
        logic              susp;
        logic              resm;
        logic [OPA_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } dec_t;

    dec_t q, d;

    logic       hit_unl1, hit_unl2, hit_query;
    logic [7:0] cmd;
    logic [OPA_W-1:0]  tgt_addr;
    logic [DATA_W-1:0] tgt_data;

    fcd_addr_match #(.CMP_W(CMP_W)) u_match (
        .addr_low  (wr_addr[CMP_W-1:0]),
        .lsb       (byte_lsb),
        .byte_mode (byte_mode),
        .hit_unl1  (hit_unl1),
        .hit_unl2  (hit_unl2),
        .hit_query (hit_query)
    );

    fcd_id_rom #(.DATA_W(DATA_W), .BOTTOM_BOOT(BOTTOM_BOOT)) u_id (
        .id_sel        (id_sel),
        .blk_protected (blk_protected),
        .id_word       (id_word)
    );

    assign cmd      = wr_data[7:0];
    assign tgt_addr = byte_mode ? {wr_addr, byte_lsb} : {1'b0, wr_addr};
    assign tgt_data = byte_mode ? {{(DATA_W-HALF){1'b0}}, wr_data[HALF-1:0]} : wr_data;

    always_comb begin
        d      = q;
        d.prog = 1'b0;
        d.blk  = 1'b0;
        d.chip = 1'b0;
        d.susp = 1'b0;
        d.resm = 1'b0;
        if (wr_en) begin
            if (engine_busy) begin
                if (cmd == C_SUSPEND) d.susp = 1'b1;
            end else begin
                case (q.seq)
                    SQ_IDLE: begin
                        if (q.fast) begin
                            if (cmd == C_PROGRAM)    d.seq = SQ_FPROG;
                            else if (cmd == C_IDENT) d.seq = SQ_FEXIT;
                        end else if (cmd == C_UNLOCK_A && hit_unl1) begin
                            d.seq = SQ_UNL1;
                        end else if (cmd == C_QUERY && hit_query) begin
                            d.mode = RM_CFI;
                        end else if (cmd == C_RESET) begin
                            if (q.mode != RM_HIDDEN) d.mode = RM_ARRAY;
                        end else if (cmd == C_BLKERA) begin
                            d.resm = 1'b1;
                        end
                    end
                    SQ_UNL1: begin
                        d.seq = (cmd == C_UNLOCK_B && hit_unl2) ? SQ_UNL2 : SQ_IDLE;
                    end
                    SQ_UNL2: begin
                        d.seq = SQ_IDLE;
                        case (cmd)
                            C_RESET:   if (q.mode != RM_HIDDEN) d.mode = RM_ARRAY;
                            C_IDENT:   if (q.mode == RM_HIDDEN) d.seq = SQ_HEXIT;
                                       else d.mode = RM_ID;
                            C_PROGRAM: d.seq  = SQ_PROG;
                            C_ERASE:   d.seq  = SQ_ERA3;
                            C_FASTSET: d.fast = 1'b1;
                            C_HIDDEN:  d.mode = RM_HIDDEN;
                            default:   d.seq  = SQ_IDLE;
                        endcase
                    end
                    SQ_PROG, SQ_FPROG: begin
                        d.seq  = SQ_IDLE;
                        d.prog = 1'b1;
                        d.addr = tgt_addr;
                        d.data = tgt_data;
                    end
                    SQ_ERA3: begin
                        d.seq = (cmd == C_UNLOCK_A && hit_unl1) ? SQ_ERA4 : SQ_IDLE;
                    end
                    SQ_ERA4: begin
                        d.seq = (cmd == C_UNLOCK_B && hit_unl2) ? SQ_ERA5 : SQ_IDLE;
                    end
                    SQ_ERA5: begin
                        d.seq = SQ_IDLE;
                        if (cmd == C_BLKERA) begin
                            d.blk  = 1'b1;
                            d.addr = tgt_addr;
                        end else if (cmd == C_CHIPERA && hit_unl1) begin
                            d.chip = 1'b1;
                            d.addr = tgt_addr;
                        end
                    end
                    SQ_HEXIT: begin
                        d.seq = SQ_IDLE;
                        if (cmd == C_ZERO) d.mode = RM_ARRAY;
                    end
                    SQ_FEXIT: begin
                        d.seq = SQ_IDLE;
                        if (cmd == C_RESET || cmd == C_ZERO) d.fast = 1'b0;
                    end
                    default: d.seq = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.seq  <= SQ_IDLE;
            q.mode <= RM_ARRAY;
            q.fast <= 1'b0;
            q.prog <= 1'b0;
            q.blk  <= 1'b0;
            q.chip <= 1'b0;
            q.susp <= 1'b0;
            q.resm <= 1'b0;
            q.addr <= '0;
            q.data <= '0;
        end else begin
            q <= d;
        end
    end

    assign read_mode      = q.mode;
    assign fast_mode      = q.fast;
    assign prog_stb       = q.prog;
    assign erase_blk_stb  = q.blk;
    assign erase_chip_stb = q.chip;
    assign suspend_stb    = q.susp;
    assign resume_stb     = q.resm;
    assign op_addr        = q.addr;
    assign op_data        = q.data;

    // R13
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, erase_blk_stb, erase_chip_stb, suspend_stb, resume_stb}));

    // R13
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |=> !prog_stb);

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && engine_busy && wr_data[7:0] != C_SUSPEND) |=>
        ($stable(read_mode) && $stable(fast_mode) && $stable(q.seq) &&
         !prog_stb && !erase_blk_stb && !erase_chip_stb && !resume_stb));

    // R7
    suspend_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && engine_busy && wr_data[7:0] == C_SUSPEND) |=> suspend_stb);

    // R11
    unlock_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !engine_busy && q.seq == SQ_UNL1 &&
         !(wr_data[7:0] == C_UNLOCK_B && hit_unl2)) |=>
        (q.seq == SQ_IDLE && $stable(read_mode)));

    // R5
    prog_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_stb) |-> ($past(wr_en) && !$past(engine_busy)));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 22;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          byte_lsb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          byte_mode = 1'b0;
    logic          engine_busy = 1'b0;
    logic [2:0]    id_sel = 3'b000;
    logic          blk_protected = 1'b0;
    logic [1:0]    read_mode;
    logic          fast_mode, prog_stb, erase_blk_stb, erase_chip_stb, suspend_stb, resume_stb;
    logic [AW:0]   op_addr;
    logic [DW-1:0] op_data, id_word;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .byte_lsb(byte_lsb),
        .wr_data(wr_data), .byte_mode(byte_mode), .engine_busy(engine_busy),
        .id_sel(id_sel), .blk_protected(blk_protected), .read_mode(read_mode),
        .fast_mode(fast_mode), .prog_stb(prog_stb), .erase_blk_stb(erase_blk_stb),
        .erase_chip_stb(erase_chip_stb), .suspend_stb(suspend_stb), .resume_stb(resume_stb),
        .op_addr(op_addr), .op_data(op_data), .id_word(id_word)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // step: 0 idle, 1 after AA, 2 after AA/55, 3 await program data,
    // 4/5/6 erase steps, 7 await hidden exit byte, 8 fast data, 9 fast exit
    int          m_step = 0;
    int          m_mode = 0;
    bit          m_fast = 0;
    bit [4:0]    m_stb = '0;   // {prog, blk, chip, susp, resm}
    logic [AW:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_mode = 0; m_fast = 0; m_stb = '0; m_addr = '0; m_data = '0;
        end else begin
            m_stb = '0;
            if (wr_en) begin
                int key, a1, a2, aq, c;
                logic [AW:0] ta;
                logic [DW-1:0] td;
                c   = int'(wr_data[7:0]);
                key = byte_mode ? int'(wr_addr[10:0]) * 2 + int'(byte_lsb) : int'(wr_addr[10:0]);
                a1  = byte_mode ? 'hAAA : 'h555;
                a2  = byte_mode ? 'h555 : 'h2AA;
                aq  = byte_mode ? 'h0AA : 'h055;
                ta  = byte_mode ? {wr_addr, byte_lsb} : {1'b0, wr_addr};
                td  = byte_mode ? {8'h00, wr_data[7:0]} : wr_data;
                if (engine_busy) begin
                    if (c == 'hB0) m_stb[1] = 1;
                end else if (m_step == 0 && m_fast) begin
                    if (c == 'hA0) m_step = 8;
                    else if (c == 'h90) m_step = 9;
                end else if (m_step == 0) begin
                    if (c == 'hAA && key == a1) m_step = 1;
                    else if (c == 'h98 && key == aq) m_mode = 2;
                    else if (c == 'hF0) begin if (m_mode != 3) m_mode = 0; end
                    else if (c == 'h30) m_stb[0] = 1;
                end else if (m_step == 1) begin
                    m_step = (c == 'h55 && key == a2) ? 2 : 0;
                end else if (m_step == 2) begin
                    m_step = 0;
                    if (c == 'hF0 && m_mode != 3) m_mode = 0;
                    else if (c == 'h90) begin if (m_mode == 3) m_step = 7; else m_mode = 1; end
                    else if (c == 'hA0) m_step = 3;
                    else if (c == 'h80) m_step = 4;
                    else if (c == 'h20) m_fast = 1;
                    else if (c == 'h88) m_mode = 3;
                end else if (m_step == 3 || m_step == 8) begin
                    m_step = 0; m_stb[4] = 1; m_addr = ta; m_data = td;
                end else if (m_step == 4) begin
                    m_step = (c == 'hAA && key == a1) ? 5 : 0;
                end else if (m_step == 5) begin
                    m_step = (c == 'h55 && key == a2) ? 6 : 0;
                end else if (m_step == 6) begin
                    m_step = 0;
                    if (c == 'h30) begin m_stb[3] = 1; m_addr = ta; end
                    else if (c == 'h10 && key == a1) begin m_stb[2] = 1; m_addr = ta; end
                end else if (m_step == 7) begin
                    m_step = 0; if (c == 0) m_mode = 0;
                end else begin
                    m_step = 0; if (c == 'hF0 || c == 0) m_fast = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(read_mode == 2'(m_mode), "R4 model read_mode", 32'(read_mode), 32'(m_mode));
            chk(fast_mode == m_fast, "R8 model fast_mode", 32'(fast_mode), 32'(m_fast));
            chk({prog_stb, erase_blk_stb, erase_chip_stb, suspend_stb, resume_stb} == m_stb,
                "R13 model strobes", 32'({prog_stb, erase_blk_stb, erase_chip_stb, suspend_stb, resume_stb}),
                32'(m_stb));
            chk(op_addr == m_addr, "R5 model op_addr", 32'(op_addr), 32'(m_addr));
            chk(op_data == m_data, "R5 model op_data", 32'(op_data), 32'(m_data));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] dt, input logic l = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dt; byte_lsb = l;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        if (byte_mode) begin wr(22'h555, 16'h00AA, 1'b0); wr(22'h2AA, 16'h0055, 1'b1); end
        else begin wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(read_mode == 2'd0, "R1 mode", 32'(read_mode), 0);
        chk(fast_mode == 1'b0, "R1 fast", 32'(fast_mode), 0);
        chk({prog_stb, erase_blk_stb, erase_chip_stb, suspend_stb, resume_stb} == 5'b0, "R1 strobes",
            32'({prog_stb, erase_blk_stb, erase_chip_stb, suspend_stb, resume_stb}), 0);

        // R4 ID entry and words
        unlock(); wr(22'h12345, 16'h0090);
        chk(read_mode == 2'd1, "R4 id mode", 32'(read_mode), 1);
        id_sel = 3'b000; #1 chk(id_word == 16'h0098, "R4 mfr", 32'(id_word), 32'h98);
        id_sel = 3'b001; #1 chk(id_word == 16'h0093, "R4 dev", 32'(id_word), 32'h93);
        id_sel = 3'b010; blk_protected = 1'b1;
        #1 chk(id_word == 16'h0001, "R4 prot", 32'(id_word), 1);
        blk_protected = 1'b0; #1 chk(id_word == 16'h0000, "R4 unprot", 32'(id_word), 0);
        id_sel = 3'b111; #1 chk(id_word == 16'h0000, "R4 other", 32'(id_word), 0);
        // R11 mismatch inside ID keeps mode
        wr(22'h0, 16'h0012);
        chk(read_mode == 2'd1, "R11 keep id", 32'(read_mode), 1);
        // R3 single reset
        wr(22'h3ABCD, 16'h00F0);
        chk(read_mode == 2'd0, "R3 single reset", 32'(read_mode), 0);

        // R2 upper address bits and upper data byte ignored
        wr(22'h3FF555, 16'hFFAA); wr(22'h1002AA, 16'h1255); wr(22'h200555, 16'hEE90);
        chk(read_mode == 2'd1, "R2 upper bits ignored", 32'(read_mode), 1);
        // R3 reset as third cycle
        unlock(); wr(22'h0, 16'h00F0);
        chk(read_mode == 2'd0, "R3 third cycle reset", 32'(read_mode), 0);

        // R10 query then R11 keep
        wr(22'h055, 16'h0098);
        chk(read_mode == 2'd2, "R10 query", 32'(read_mode), 2);
        wr(22'h777, 16'h0044);
        chk(read_mode == 2'd2, "R11 keep query", 32'(read_mode), 2);
        wr(22'h0, 16'h00F0);

        // R5 program
        unlock(); wr(22'h555, 16'h00A0); wr(22'h2ABCD, 16'h1234);
        chk(prog_stb == 1'b1, "R5 prog strobe", 32'(prog_stb), 1);
        chk(op_addr == 23'h02ABCD, "R5 prog addr", 32'(op_addr), 32'h2ABCD);
        chk(op_data == 16'h1234, "R5 prog data", 32'(op_data), 32'h1234);
        @(negedge clk);
        chk(prog_stb == 1'b0, "R13 one clock", 32'(prog_stb), 0);

        // R6 block and chip erase
        unlock(); wr(22'h555, 16'h0080); unlock(); wr(22'h3A000, 16'h0030);
        chk(erase_blk_stb == 1'b1, "R6 block erase", 32'(erase_blk_stb), 1);
        chk(op_addr == 23'h03A000, "R6 block addr", 32'(op_addr), 32'h3A000);
        unlock(); wr(22'h555, 16'h0080); unlock(); wr(22'h555, 16'h0010);
        chk(erase_chip_stb == 1'b1, "R6 chip erase", 32'(erase_chip_stb), 1);
        unlock(); wr(22'h555, 16'h0080); unlock(); wr(22'h123, 16'h0010);
        chk(erase_chip_stb == 1'b0, "R6 chip wrong addr", 32'(erase_chip_stb), 0);

        // R11 broken unlock aborts
        wr(22'h555, 16'h00AA); wr(22'h2AB, 16'h0055); wr(22'h555, 16'h00A0); wr(22'h100, 16'h5555);
        chk(prog_stb == 1'b0, "R11 broken unlock", 32'(prog_stb), 0);

        // R7/R12 suspend while an erase sequence is held
        unlock(); wr(22'h555, 16'h0080); unlock();
        engine_busy = 1'b1;
        wr(22'h8000, 16'h00B0);
        chk(suspend_stb == 1'b1, "R7 suspend", 32'(suspend_stb), 1);
        wr(22'h3A000, 16'h0030);
        chk(erase_blk_stb == 1'b0 && resume_stb == 1'b0, "R12 busy ignore",
            32'({erase_blk_stb, resume_stb}), 0);
        wr(22'h055, 16'h0098);
        chk(read_mode == 2'd0, "R12 busy query ignored", 32'(read_mode), 0);
        engine_busy = 1'b0;
        wr(22'h3B000, 16'h0030);
        chk(erase_blk_stb == 1'b1, "R12 held sequence completes", 32'(erase_blk_stb), 1);
        wr(22'h8000, 16'h0030);
        chk(resume_stb == 1'b1, "R7 resume", 32'(resume_stb), 1);

        // R8 fast mode
        unlock(); wr(22'h555, 16'h0020);
        chk(fast_mode == 1'b1, "R8 fast set", 32'(fast_mode), 1);
        wr(22'h0, 16'h0098);
        chk(read_mode == 2'd0, "R8 other write no effect", 32'(read_mode), 0);
        wr(22'h0, 16'h00A0); wr(22'h100, 16'hBEEF);
        chk(prog_stb == 1'b1 && op_data == 16'hBEEF, "R8 fast program", 32'(op_data), 32'hBEEF);
        wr(22'h0, 16'h0090); wr(22'h0, 16'h0000);
        chk(fast_mode == 1'b0, "R8 exit 00", 32'(fast_mode), 0);
        unlock(); wr(22'h555, 16'h0020); wr(22'h0, 16'h0090); wr(22'h0, 16'h00F0);
        chk(fast_mode == 1'b0, "R8 exit F0", 32'(fast_mode), 0);

        // R9 hidden area
        unlock(); wr(22'h555, 16'h0088);
        chk(read_mode == 2'd3, "R9 hidden", 32'(read_mode), 3);
        wr(22'h0, 16'h00F0);
        chk(read_mode == 2'd3, "R3 F0 keeps hidden", 32'(read_mode), 3);
        unlock(); wr(22'h555, 16'h0090); wr(22'h0, 16'h0000);
        chk(read_mode == 2'd0, "R9 hidden exit", 32'(read_mode), 0);

        // R2 byte mode
        byte_mode = 1'b1;
        wr(22'h2AA, 16'h00AA, 1'b1); wr(22'h155, 16'h0055, 1'b0); wr(22'h0, 16'h0090);
        chk(read_mode == 2'd0, "R2 word addr rejected in byte mode", 32'(read_mode), 0);
        unlock(); wr(22'h0, 16'h0090);
        chk(read_mode == 2'd1, "R2 byte unlock", 32'(read_mode), 1);
        wr(22'h0, 16'h00F0);
        wr(22'h055, 16'h0098, 1'b0);
        chk(read_mode == 2'd2, "R10 byte query", 32'(read_mode), 2);
        wr(22'h0, 16'h00F0);
        unlock(); wr(22'h555, 16'h00A0, 1'b0); wr(22'h10, 16'hAB5C, 1'b1);
        chk(op_addr == 23'h000021, "R5 byte addr", 32'(op_addr), 32'h21);
        chk(op_data == 16'h005C, "R5 byte data", 32'(op_data), 32'h5C);
        byte_mode = 1'b0;

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule